// File: doc/BRIEF.md
# Two-Channel Peripheral-to-Memory DMA Engine

This block moves data, one item at a time, between a fixed peripheral register address and a memory address that steps forward after every move. There are two independent channels. Each has its own settings and its own completion interrupt. Software configures a channel through a small register port. The enable bit must be set first, because writes to the other settings of a disabled channel are dropped. Software then loads the direction, the item size, the trigger source, both addresses and the count, and finally arms the channel.

An armed channel waits for a trigger. The trigger is either a self-clearing software bit or one of the hardware interrupt lines, picked by a 4-bit selector. On a trigger the channel raises a bus request and holds it until the fabric grants. The move takes place in the grant cycle. The memory address then advances by the item size and the count drops by one. When the count runs out, the channel disarms itself and pulses its interrupt. Channel 0 wins when both channels request. A trigger that arrives while a channel is busy is held as a single pending request.

Top module: `dma2ch_top`

Register map: the channel is chosen by `reg_addr[3]`, and the field by `reg_addr[2:0]`:

| `reg_addr[2:0]` | Field | Contents |
|---|---|---|
| 0 | CTRL | bit0 = enable, bit1 = arm, bit2 = software trigger |
| 1 | MODE | bit0 = direction, bit1 = 16-bit items, bits[7:4] = trigger-source select |
| 2 | PADDR | peripheral address |
| 3 | MADDR | memory address |
| 4 | COUNT | transfer count |

## Requirements
- R1: After reset every register of both channels reads 0, and bus_req and done_irq are low.
- R2: While a channel's enable (CTRL bit0) is 0, writes to its MODE (field 1), PADDR (field 2), MADDR (field 3) and COUNT (field 4) are ignored. A CTRL write only sets arm (bit1) or software trigger (bit2) if the same write also sets enable.
- R3: A channel whose arm bit is 0 ignores both hardware and software triggers and does not raise bus_req.
- R4: An armed channel is triggered by hw_irq[sel], where sel is MODE bits[7:4], or by its software trigger. bus_req is high in the cycle after the trigger cycle.
- R5: bus_req stays high until bus_gnt. One item moves in each cycle where both are high. With MODE bit0 = 0 the source is PADDR and the destination is MADDR; with bit0 = 1 the two are swapped. bus_wide equals MODE bit1.
- R6: After each move, MADDR rises by 1 (MODE bit1 = 0) or by 2 (MODE bit1 = 1), COUNT falls by 1, and PADDR is unchanged.
- R7: The move that brings COUNT to 0 clears the arm bit. The channel's done_irq bit is then high for exactly one cycle, the cycle after that move.
- R8: A COUNT of 0 at arm time gives 65536 moves before completion. The memory address wraps at its width.
- R9: When both channels request, channel 0 is presented on the bus and granted first.
- R10: Triggers that arrive while a channel is waiting for or finishing a move collapse into one pending request, which starts the next move.
- R11: The software trigger bit reads 1 for exactly one cycle after it is written and 0 after that.
- R12: Writing CTRL with enable or arm at 0 disarms the channel, drops any pending request, and lowers bus_req from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Bit 3 is the channel, bits 2:0 the field |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| hw_irq | input | 16 | Hardware trigger sources |
| bus_req | output | 1 | A channel requests the bus |
| bus_gnt | input | 1 | Bus grant; a move takes place when it is high together with bus_req |
| bus_src | output | 16 | Source address of the presented move |
| bus_dst | output | 16 | Destination address of the presented move |
| bus_wide | output | 1 | Presented move is 16-bit |
| done_irq | output | 2 | Per-channel completion pulse |

## Verification
The main function is exercised with four kinds of input:
- Hardware pulses spaced apart under a constant grant. These show the request timing and the byte-step address sequence.
- Back-to-back software triggers in the swapped 16-bit direction. These separate the direction and size handling from the hardware path.
- A burst of triggers under a withheld grant. This tells a single pending flag apart from a counting one.
- A shared trigger hitting both channels at once, and a held trigger with a zero count. These expose the priority order and the 65536-move wrap.

A scoreboard of expected source, destination and size, in order, catches any extra, missing or misplaced move.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;

   typedef enum logic [2:0] {
      FLD_CTRL  = 3'd0,
      FLD_MODE  = 3'd1,
      FLD_PADDR = 3'd2,
      FLD_MADDR = 3'd3,
      FLD_COUNT = 3'd4
   } fld_e;

   typedef enum logic {
      ST_IDLE,
      ST_REQ
   } ch_state_e;

   localparam int FLD_W     = 3;
   localparam int CTRL_EN   = 0;
   localparam int CTRL_ARM  = 1;
   localparam int CTRL_SW   = 2;
   localparam int MODE_DIR  = 0;
   localparam int MODE_WIDE = 1;
   localparam int MODE_SEL  = 4;

endpackage

// File: rtl/dma2ch_arb.sv
module dma2ch_arb #(
   parameter int NCH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH-1:0]          req,
   input  logic                    gnt_in,
   output logic [NCH-1:0]          gnt,
   output logic [$clog2(NCH)-1:0]  sel
);
   localparam int CH_W = $clog2(NCH);

   // fixed priority: lowest index wins
   always_comb begin
      logic found;
      found = 1'b0;
      gnt   = '0;
      sel   = '0;
      for (int c = 0; c < NCH; c++) begin
         if (req[c] && !found) begin
            found  = 1'b1;
            sel    = CH_W'(c);
            gnt[c] = gnt_in;
         end
      end
   end

   assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> !gnt[NCH-1:1]);

endmodule

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
   import dma2ch_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CW    = 16,
   parameter int DW    = 16,
   parameter int SRC_N = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  fld_e             wr_fld,
   input  logic [DW-1:0]    wr_data,
   input  fld_e             rd_fld,
   output logic [DW-1:0]    rd_data,
   input  logic [SRC_N-1:0] hw_src,
   input  logic             gnt,
   output logic             req,
   output logic [AW-1:0]    src_addr,
   output logic [AW-1:0]    dst_addr,
   output logic             wide,
   output logic             done
);
   localparam int SEL_W = $clog2(SRC_N);

   logic             en_q, arm_q, sw_q, dir_q, wide_q, pend_q, done_q;
   logic [SEL_W-1:0] sel_q;
   logic [AW-1:0]    paddr_q, maddr_q;
   logic [CW-1:0]    cnt_q;
   ch_state_e        state_q;

   logic ctrl_wr, cfg_wr, keep_armed, trig, xfer, last;
   logic [AW-1:0] step;

   assign ctrl_wr    = wr_en && (wr_fld == FLD_CTRL);
   assign cfg_wr     = wr_en && (wr_fld != FLD_CTRL) && en_q;
   assign keep_armed = wr_data[CTRL_EN] && wr_data[CTRL_ARM];
   assign trig       = arm_q && (sw_q || hw_src[sel_q]);
   assign xfer       = (state_q == ST_REQ) && gnt;
   assign last       = xfer && (cnt_q == CW'(1));
   assign step       = wide_q ? AW'(2) : AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         arm_q   <= 1'b0;
         sw_q    <= 1'b0;
         dir_q   <= 1'b0;
         wide_q  <= 1'b0;
         sel_q   <= '0;
         paddr_q <= '0;
         maddr_q <= '0;
         cnt_q   <= '0;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
         state_q <= ST_IDLE;
      end else begin
         sw_q   <= ctrl_wr && wr_data[CTRL_EN] && wr_data[CTRL_SW];
         done_q <= last;
         if (ctrl_wr) en_q <= wr_data[CTRL_EN];
         if (last)         arm_q <= 1'b0;
         else if (ctrl_wr) arm_q <= keep_armed;
         if (cfg_wr && wr_fld == FLD_MODE) begin
            dir_q  <= wr_data[MODE_DIR];
            wide_q <= wr_data[MODE_WIDE];
            sel_q  <= wr_data[MODE_SEL +: SEL_W];
         end
         if (cfg_wr && wr_fld == FLD_PADDR) paddr_q <= wr_data[AW-1:0];
         if (xfer)                               maddr_q <= maddr_q + step;
         else if (cfg_wr && wr_fld == FLD_MADDR) maddr_q <= wr_data[AW-1:0];
         if (xfer)                               cnt_q <= cnt_q - CW'(1);
         else if (cfg_wr && wr_fld == FLD_COUNT) cnt_q <= wr_data[CW-1:0];

         if (ctrl_wr && !keep_armed) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
         end else begin
            case (state_q)
               ST_IDLE: if (trig) state_q <= ST_REQ;
               ST_REQ: begin
                  if (xfer) begin
                     if (last) begin
                        state_q <= ST_IDLE;
                     end else if (pend_q || trig) begin
                        state_q <= ST_REQ;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                     pend_q <= 1'b0;
                  end else begin
                     pend_q <= pend_q || trig;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign req      = (state_q == ST_REQ);
   assign src_addr = dir_q ? maddr_q : paddr_q;
   assign dst_addr = dir_q ? paddr_q : maddr_q;
   assign wide     = wide_q;
   assign done     = done_q;

   always_comb begin
      rd_data = '0;
      case (rd_fld)
         FLD_CTRL: begin
            rd_data[CTRL_EN]  = en_q;
            rd_data[CTRL_ARM] = arm_q;
            rd_data[CTRL_SW]  = sw_q;
         end
         FLD_MODE: begin
            rd_data[MODE_DIR]            = dir_q;
            rd_data[MODE_WIDE]           = wide_q;
            rd_data[MODE_SEL +: SEL_W]   = sel_q;
         end
         FLD_PADDR: rd_data[AW-1:0] = paddr_q;
         FLD_MADDR: rd_data[AW-1:0] = maddr_q;
         FLD_COUNT: rd_data[CW-1:0] = cnt_q;
         default:   rd_data = '0;
      endcase
   end

   assert_req_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> arm_q);

   assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req && !gnt && !ctrl_wr |=> req);

   assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> cnt_q == $past(cnt_q) - CW'(1));

   assert_maddr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> maddr_q == $past(maddr_q) + ($past(wide_q) ? AW'(2) : AW'(1)));

   assert_paddr_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && !cfg_wr |=> $stable(paddr_q));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !arm_q);

   assert_no_req_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !req);

endmodule

// File: rtl/dma2ch_top.sv
module dma2ch_top
   import dma2ch_pkg::*;
#(
   parameter int NCH   = 2,
   parameter int AW    = 16,
   parameter int CW    = 16,
   parameter int DW    = 16,
   parameter int SRC_N = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_we,
   input  logic [$clog2(NCH)+2:0]    reg_addr,
   input  logic [DW-1:0]             reg_wdata,
   output logic [DW-1:0]             reg_rdata,
   input  logic [SRC_N-1:0]          hw_irq,
   output logic                      bus_req,
   input  logic                      bus_gnt,
   output logic [AW-1:0]             bus_src,
   output logic [AW-1:0]             bus_dst,
   output logic                      bus_wide,
   output logic [NCH-1:0]            done_irq
);
   localparam int CH_W  = $clog2(NCH);
   localparam int RA_W  = CH_W + FLD_W;
   localparam int SEL_W = $clog2(SRC_N);

   if (NCH < 2)                 begin : g_bad_nch  $error("NCH must be at least 2"); end
   if (DW < AW || DW < CW)      begin : g_bad_dw   $error("DW must hold an address and a count"); end
   if (SRC_N != (1 << SEL_W))   begin : g_bad_src  $error("SRC_N must be a power of two"); end
   if (DW < MODE_SEL + SEL_W)   begin : g_bad_sel  $error("DW too narrow for the source select"); end
   if (CW < 2)                  begin : g_bad_cw   $error("CW must be at least 2"); end

   logic [CH_W-1:0] ch_idx;
   fld_e            fld;
   logic [NCH-1:0]  ch_req, ch_gnt, ch_wide;
   logic [AW-1:0]   ch_src [NCH];
   logic [AW-1:0]   ch_dst [NCH];
   logic [DW-1:0]   ch_rd  [NCH];
   logic [CH_W-1:0] arb_sel;

   assign ch_idx = reg_addr[RA_W-1:FLD_W];
   assign fld    = fld_e'(reg_addr[FLD_W-1:0]);

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      dma2ch_chan #(
         .AW(AW), .CW(CW), .DW(DW), .SRC_N(SRC_N)
      ) i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (reg_we && (ch_idx == CH_W'(g))),
         .wr_fld   (fld),
         .wr_data  (reg_wdata),
         .rd_fld   (fld),
         .rd_data  (ch_rd[g]),
         .hw_src   (hw_irq),
         .gnt      (ch_gnt[g]),
         .req      (ch_req[g]),
         .src_addr (ch_src[g]),
         .dst_addr (ch_dst[g]),
         .wide     (ch_wide[g]),
         .done     (done_irq[g])
      );
   end

   dma2ch_arb #(.NCH(NCH)) i_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (ch_req),
      .gnt_in (bus_gnt),
      .gnt    (ch_gnt),
      .sel    (arb_sel)
   );

   assign bus_req = |ch_req;

   always_comb begin
      bus_src  = '0;
      bus_dst  = '0;
      bus_wide = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         if (arb_sel == CH_W'(c)) begin
            bus_src  = ch_src[c];
            bus_dst  = ch_dst[c];
            bus_wide = ch_wide[c];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NCH; c++) begin
         if (ch_idx == CH_W'(c)) reg_rdata = ch_rd[c];
      end
   end

   assert_grant_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |-> (ch_gnt == '0));

endmodule

// File: tb/test_dma2ch_top.sv
`timescale 1ns/1ps
module test_dma2ch_top;

   localparam int F_CTRL = 0, F_MODE = 1, F_PADDR = 2, F_MADDR = 3, F_COUNT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [15:0] hw_irq = '0;
   logic        bus_req;
   logic        bus_gnt = 1'b0;
   logic [15:0] bus_src, bus_dst;
   logic        bus_wide;
   logic [1:0]  done_irq;

   int total = 0;
   int bad   = 0;
   int irq_cnt [2];
   logic [32:0] expq [$];
   logic [15:0] v;

   always #4 clk = ~clk;

   dma2ch_top i_dma2ch_top (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_irq(hw_irq),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_src(bus_src),
      .bus_dst(bus_dst), .bus_wide(bus_wide), .done_irq(done_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic wr(input int ch, input int fld, input logic [15:0] d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = 4'(ch * 8 + fld);
      reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int ch, input int fld, output logic [15:0] d);
      reg_addr = 4'(ch * 8 + fld);
      #2;
      d = reg_rdata;
   endtask

   task automatic pulse(input int b);
      @(negedge clk);
      hw_irq[b] = 1'b1;
      @(negedge clk);
      hw_irq[b] = 1'b0;
   endtask

   task automatic push(input logic [15:0] s, input logic [15:0] d, input logic w);
      expq.push_back({s, d, w});
   endtask

   // monitor: compares every bus move against the scoreboard
   initial begin
      irq_cnt[0] = 0;
      irq_cnt[1] = 0;
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && bus_req && bus_gnt) begin
            total++;
            if (expq.size() == 0) begin
               bad++;
               $display("FAIL R5 unexpected move: actual=%h expected=none",
                        {bus_src, bus_dst, bus_wide});
            end else begin
               logic [32:0] e;
               e = expq.pop_front();
               if ({bus_src, bus_dst, bus_wide} !== e) begin
                  bad++;
                  $display("FAIL R5/R6 move: actual=%h expected=%h",
                           {bus_src, bus_dst, bus_wide}, e);
               end
            end
         end
         for (int c = 0; c < 2; c++) if (done_irq[c]) irq_cnt[c]++;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(0, F_CTRL, v);  chk("R1 ctrl0", v, 0);
      rd(1, F_COUNT, v); chk("R1 count1", v, 0);
      chk("R1 bus_req", bus_req, 0);
      chk("R1 done_irq", done_irq, 0);

      // R2 writes ignored while disabled
      wr(0, F_PADDR, 16'h1234);
      rd(0, F_PADDR, v); chk("R2 paddr ignored", v, 0);
      wr(0, F_CTRL, 16'h0006);
      rd(0, F_CTRL, v); chk("R2 arm without enable", v, 0);
      repeat (3) @(negedge clk);
      #2 chk("R2 no request", bus_req, 0);

      wr(0, F_CTRL, 16'h0001);
      wr(0, F_MODE, 16'h0030);
      wr(0, F_PADDR, 16'h0040);
      wr(0, F_MADDR, 16'h1000);
      wr(0, F_COUNT, 16'h0003);
      rd(0, F_PADDR, v); chk("R2 paddr when enabled", v, 16'h0040);

      // R3 unarmed channel ignores triggers
      bus_gnt = 1'b1;
      pulse(3);
      repeat (3) @(negedge clk);
      #2 chk("R3 no request unarmed", bus_req, 0);

      // R4 / R6 / R7 byte mode, peripheral to memory
      wr(0, F_CTRL, 16'h0003);
      push(16'h0040, 16'h1000, 0);
      push(16'h0040, 16'h1001, 0);
      push(16'h0040, 16'h1002, 0);
      pulse(3);
      #2 chk("R4 request after trigger", bus_req, 1);
      repeat (3) @(negedge clk);
      pulse(3);
      repeat (3) @(negedge clk);
      pulse(3);
      #2;
      @(negedge clk); #2 chk("R7 done pulse", done_irq[0], 1);
      @(negedge clk); #2 chk("R7 done one cycle", done_irq[0], 0);
      repeat (2) @(negedge clk);
      chk("R6 scoreboard drained", expq.size(), 0);
      chk("R7 irq count ch0", irq_cnt[0], 1);
      rd(0, F_CTRL, v);  chk("R7 arm cleared", v, 16'h0001);
      rd(0, F_MADDR, v); chk("R6 maddr byte step", v, 16'h1003);
      rd(0, F_COUNT, v); chk("R6 count zero", v, 0);
      rd(0, F_PADDR, v); chk("R6 paddr fixed", v, 16'h0040);

      // R11 / R5 software trigger, memory to peripheral, 16-bit
      wr(1, F_CTRL, 16'h0001);
      wr(1, F_MODE, 16'h0003);
      wr(1, F_PADDR, 16'h0080);
      wr(1, F_MADDR, 16'h2000);
      wr(1, F_COUNT, 16'h0002);
      wr(1, F_CTRL, 16'h0003);
      push(16'h2000, 16'h0080, 1);
      push(16'h2002, 16'h0080, 1);
      wr(1, F_CTRL, 16'h0007);
      rd(1, F_CTRL, v); chk("R11 sw bit high", v, 16'h0007);
      @(negedge clk);
      rd(1, F_CTRL, v); chk("R11 sw bit cleared", v, 16'h0003);
      repeat (3) @(negedge clk);
      wr(1, F_CTRL, 16'h0007);
      repeat (5) @(negedge clk);
      chk("R5 swapped wide moves", expq.size(), 0);
      chk("R7 irq count ch1", irq_cnt[1], 1);
      rd(1, F_MADDR, v); chk("R6 maddr wide step", v, 16'h2004);

      // R10 pending collapse, R5 request held
      bus_gnt = 1'b0;
      wr(0, F_PADDR, 16'h0010);
      wr(0, F_MADDR, 16'h0300);
      wr(0, F_COUNT, 16'h0005);
      wr(0, F_CTRL, 16'h0003);
      @(negedge clk); hw_irq[3] = 1'b1;
      repeat (3) @(negedge clk);
      hw_irq[3] = 1'b0;
      repeat (3) @(negedge clk);
      #2 chk("R5 request held", bus_req, 1);
      push(16'h0010, 16'h0300, 0);
      push(16'h0010, 16'h0301, 0);
      @(negedge clk); bus_gnt = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10 two moves only", expq.size(), 0);
      rd(0, F_COUNT, v); chk("R10 count", v, 16'h0003);
      chk("R10 request idle", bus_req, 0);

      // R12 disable drops request
      bus_gnt = 1'b0;
      pulse(3);
      #2 chk("R12 request before disable", bus_req, 1);
      wr(0, F_CTRL, 16'h0000);
      #2 chk("R12 request dropped", bus_req, 0);
      rd(0, F_CTRL, v); chk("R12 ctrl cleared", v, 0);
      wr(0, F_CTRL, 16'h0001);

      // R9 priority
      wr(0, F_COUNT, 16'h0001);
      wr(0, F_CTRL, 16'h0003);
      wr(1, F_MODE, 16'h0030);
      wr(1, F_PADDR, 16'h0080);
      wr(1, F_MADDR, 16'h4000);
      wr(1, F_COUNT, 16'h0001);
      wr(1, F_CTRL, 16'h0003);
      push(16'h0010, 16'h0302, 0);
      push(16'h0080, 16'h4000, 0);
      pulse(3);
      #2 chk("R9 ch0 presented", bus_src, 16'h0010);
      @(negedge clk); bus_gnt = 1'b1;
      repeat (5) @(negedge clk);
      chk("R9 order", expq.size(), 0);
      chk("R9 irq ch0", irq_cnt[0], 2);
      chk("R9 irq ch1", irq_cnt[1], 2);

      // R8 zero count means 65536 moves
      wr(1, F_MODE, 16'h0050);
      wr(1, F_PADDR, 16'h0077);
      wr(1, F_MADDR, 16'h0000);
      wr(1, F_COUNT, 16'h0000);
      wr(1, F_CTRL, 16'h0003);
      for (int i = 0; i < 65536; i++) push(16'h0077, 16'(i), 0);
      @(negedge clk); hw_irq[5] = 1'b1;
      while (irq_cnt[1] < 3) @(negedge clk);
      hw_irq[5] = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 all moves done", expq.size(), 0);
      rd(1, F_MADDR, v); chk("R8 maddr wrapped", v, 16'h0000);
      rd(1, F_CTRL, v);  chk("R8 disarmed", v, 16'h0001);

      finish_run();
   end

endmodule